// File: doc/BRIEF.md
# Multi-Polynomial Reseeding Scan Pattern Generator

This block produces deterministic scan loads for built-in self-test. It walks a list of encoded words held in an external seed memory. Each word packs a feedback-polynomial selector next to a linear feedback shift register (LFSR) seed. For each word the block reads the memory and loads the seed into its LFSR in parallel. It switches the LFSR feedback to the polynomial the selector names. It then streams the LFSR's last stage serially into an external scan chain for exactly one chain length.

After every chain load the block pulses a ready strobe, so the surrounding test logic can capture. After the last word it pulses a completion strobe and goes idle. The set of polynomials is a parameter table indexed by the selector. Because the tap configuration changes on every reseed, a short seed can expand into a long scan load that matches a target cube on its specified bits.

The controller is a six-state machine: IDLE, FETCH, LOAD, SHIFT, READY and DONE. Its transitions are:
- IDLE→FETCH on start.
- FETCH→LOAD always.
- LOAD→SHIFT always.
- SHIFT→SHIFT until the last chain bit.
- SHIFT→READY after the last chain bit.
- READY→FETCH while words remain.
- READY→DONE after the last word.
- DONE→IDLE always.

Top module: `mpoly_reseed_gen`

## Requirements
- R1: While reset is asserted and after its release, until a start is seen, the outputs mem_rd_en, scan_en, scan_out, pattern_ready and done are all 0.
- R2: A start sampled in IDLE raises mem_rd_en for one cycle in the following cycle. The reads of one run use addresses 0, 1, …, NUM_PATTERNS-1 in order. mem_rd_en is never high together with scan_en, pattern_ready or done.
- R3: The memory returns data one cycle after mem_rd_en. In each word the upper ID_W bits are the polynomial selector and the lower LFSR_W bits are the seed. The seed is loaded in parallel. The first scan bit equals seed bit LFSR_W-1, which is the last stage.
- R4: On each shift the stages move up by one position. Stage 0 receives the XOR of the stages whose bit is set in the selected tap mask. Mask bit i stands for stage i. Selector 0 has mask 4'b1100 (x^4+x^3+1). Selector 1 has mask 4'b1001 (x^4+x+1).
- R5: scan_en is high for exactly CHAIN_LEN consecutive cycles per word. It first rises two cycles after that word's read request. scan_out is valid whenever scan_en is high.
- R6: A selector of NUM_POLYS or above uses the selector-0 polynomial.
- R7: pattern_ready is a single-cycle pulse in the cycle after the last shift cycle. The next word's read request follows in the next cycle.
- R8: done is a single-cycle pulse in the cycle after the last word's pattern_ready. The block is idle afterwards.
- R9: start is ignored while a run is in progress. A run issues exactly NUM_PATTERNS reads.
- R10: With seed 4'b0001 and selector 0, the 10-bit load, in shift order, has 0 at positions 0 and 4 and 1 at positions 3, 6 and 9. This matches the target cube on its care bits.
- R11: An all-zero seed yields CHAIN_LEN zero scan bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| mem_rd_en | output | 1 | Seed memory read request |
| mem_addr | output | ADDR_W | Seed memory word address |
| mem_rd_data | input | ID_W+LFSR_W | Encoded word, valid one cycle after the request |
| scan_en | output | 1 | Scan chain shift enable |
| scan_out | output | 1 | Serial bit into the scan chain |
| pattern_ready | output | 1 | One-cycle pulse after a complete chain load |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
Each result is due at a fixed offset from the stimulus that caused it:
- The read request comes one cycle after the start sample.
- The first shift bit comes two cycles after the request.
- pattern_ready comes CHAIN_LEN cycles after the first shift bit.
- done comes one cycle after the final pattern_ready.

The bench turns each start into a queue of expected per-cycle output tuples built from these offsets and a behavioural LFSR model. It samples one time unit after every rising edge and pops exactly one tuple per cycle, so a result one cycle early or late is reported. Chain contents captured from scan_out are additionally compared against the target cube, the fallback selector and the zero seed.

// File: rtl/mpoly_pkg.sv
package mpoly_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SHIFT,
        ST_READY,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/mpoly_tap_select.sv
module mpoly_tap_select #(
    parameter int LFSR_W    = 4,
    parameter int ID_W      = 4,
    parameter int NUM_POLYS = 2,
    parameter logic [NUM_POLYS*LFSR_W-1:0] TAP_TABLE = '0
) (
    input  logic [ID_W-1:0]   poly_id,
    output logic [LFSR_W-1:0] tap_mask
);
    localparam int SLOTS = 2 ** ID_W;

    logic [LFSR_W-1:0] mask_slot [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NUM_POLYS) begin : g_used
            assign mask_slot[g] = TAP_TABLE[g*LFSR_W +: LFSR_W];
        end else begin : g_fallback
            assign mask_slot[g] = TAP_TABLE[LFSR_W-1:0];
        end
    end

    assign tap_mask = mask_slot[poly_id];
endmodule

// File: rtl/mpoly_lfsr.sv
module mpoly_lfsr #(
    parameter int LFSR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              shift,
    input  logic [LFSR_W-1:0] tap_mask,
    output logic              serial_out
);
    logic [LFSR_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (load) begin
            stage_q <= seed;
        end else if (shift) begin
            stage_q <= {stage_q[LFSR_W-2:0], ^(stage_q & tap_mask)};
        end
    end

    assign serial_out = stage_q[LFSR_W-1];
endmodule

// File: rtl/mpoly_seq_ctrl.sv
module mpoly_seq_ctrl
    import mpoly_pkg::*;
#(
    parameter int CHAIN_LEN    = 10,
    parameter int NUM_PATTERNS = 4,
    parameter int ADDR_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              load,
    output logic              shift,
    output logic              ready,
    output logic              done
);
    localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(CHAIN_LEN - 1);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(NUM_PATTERNS - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [ADDR_W-1:0] word_ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (bit_cnt_q == LAST_BIT) state_d = ST_READY;
            ST_READY: state_d = (word_ptr_q == LAST_WORD) ? ST_DONE : ST_FETCH;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            word_ptr_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start)              word_ptr_q <= '0;
            else if (state_q == ST_READY && word_ptr_q != LAST_WORD)
                                                          word_ptr_q <= word_ptr_q + 1'b1;
            if (state_q == ST_LOAD)                       bit_cnt_q <= '0;
            else if (state_q == ST_SHIFT)                 bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    always_comb begin
        rd_en   = 1'b0;
        load    = 1'b0;
        shift   = 1'b0;
        ready   = 1'b0;
        done    = 1'b0;
        rd_addr = word_ptr_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: rd_en = 1'b1;
            ST_LOAD:  load  = 1'b1;
            ST_SHIFT: shift = 1'b1;
            ST_READY: ready = 1'b1;
            ST_DONE:  done  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/mpoly_reseed_gen.sv
module mpoly_reseed_gen #(
    parameter int LFSR_W       = 4,
    parameter int ID_W         = 4,
    parameter int CHAIN_LEN    = 10,
    parameter int NUM_PATTERNS = 4,
    parameter int NUM_POLYS    = 2,
    parameter logic [NUM_POLYS*LFSR_W-1:0] TAP_TABLE = {4'b1001, 4'b1100},
    localparam int WORD_W = ID_W + LFSR_W,
    localparam int ADDR_W = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              scan_en,
    output logic              scan_out,
    output logic              pattern_ready,
    output logic              done
);
    logic              load_w;
    logic              shift_w;
    logic              lfsr_bit;
    logic [ID_W-1:0]   poly_id_q;
    logic [LFSR_W-1:0] tap_mask;

    mpoly_seq_ctrl #(
        .CHAIN_LEN   (CHAIN_LEN),
        .NUM_PATTERNS(NUM_PATTERNS),
        .ADDR_W      (ADDR_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .rd_en  (mem_rd_en),
        .rd_addr(mem_addr),
        .load   (load_w),
        .shift  (shift_w),
        .ready  (pattern_ready),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      poly_id_q <= '0;
        else if (load_w) poly_id_q <= mem_rd_data[WORD_W-1 -: ID_W];
    end

    mpoly_tap_select #(
        .LFSR_W   (LFSR_W),
        .ID_W     (ID_W),
        .NUM_POLYS(NUM_POLYS),
        .TAP_TABLE(TAP_TABLE)
    ) u_taps (
        .poly_id (poly_id_q),
        .tap_mask(tap_mask)
    );

    mpoly_lfsr #(
        .LFSR_W(LFSR_W)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .seed      (mem_rd_data[LFSR_W-1:0]),
        .shift     (shift_w),
        .tap_mask  (tap_mask),
        .serial_out(lfsr_bit)
    );

    assign scan_en  = shift_w;
    assign scan_out = shift_w & lfsr_bit;
endmodule

// File: rtl/mpoly_reseed_gen_chk.sv
module mpoly_reseed_gen_chk #(
    parameter int CHAIN_LEN    = 10,
    parameter int NUM_PATTERNS = 4,
    parameter int ADDR_W       = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              scan_en,
    input logic              pattern_ready,
    input logic              done
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)       run_len <= 0;
        else if (scan_en) run_len <= run_len + 1;
        else              run_len <= 0;
    end

    AST_EXCLUSIVE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, scan_en, pattern_ready, done}));  // R2
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(mem_addr) < NUM_PATTERNS));  // R2
    AST_READ_TO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !scan_en ##1 scan_en);  // R5
    AST_SHIFT_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (run_len < CHAIN_LEN));  // R5
    AST_SHIFT_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (run_len == CHAIN_LEN));  // R5
    AST_READY_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> pattern_ready);  // R7
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_ready |=> !pattern_ready);  // R7
    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pattern_ready));  // R8
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !(mem_rd_en || scan_en || done));  // R8
endmodule

bind mpoly_reseed_gen mpoly_reseed_gen_chk #(
    .CHAIN_LEN   (CHAIN_LEN),
    .NUM_PATTERNS(NUM_PATTERNS),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .scan_en      (scan_en),
    .pattern_ready(pattern_ready),
    .done         (done)
);

// File: tb/mpoly_reseed_gen_bench.sv
module mpoly_reseed_gen_bench;
    localparam int K  = 4;
    localparam int Q  = 4;
    localparam int M  = 10;
    localparam int NP = 4;
    localparam int AW = 2;

    typedef struct {
        bit    rd_en;
        int    addr;
        bit    sen;
        bit    sbit;
        bit    rdy;
        bit    dn;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [Q+K-1:0] mem_rd_data = '0;
    logic          scan_en;
    logic          scan_out;
    logic          pattern_ready;
    logic          done;

    logic [Q+K-1:0] mem [NP];
    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    int   reads = 0;
    bit   finished = 0;
    bit   chain [NP][M];
    int   word_idx = 0;
    int   bit_idx = 0;

    always #2.5 clk = ~clk;

    mpoly_reseed_gen u_mpoly_reseed_gen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .scan_en(scan_en), .scan_out(scan_out),
        .pattern_ready(pattern_ready), .done(done)
    );

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

    function automatic int mask_for(int id);
        if (id == 1) return 4'b1001;
        return 4'b1100;  // R6: selector 0 and every unused selector
    endfunction

    function automatic exp_t mk(bit r, int a, bit se, bit sb, bit rd, bit d, string t);
        exp_t e;
        e.rd_en = r; e.addr = a; e.sen = se; e.sbit = sb; e.rdy = rd; e.dn = d; e.tag = t;
        return e;
    endfunction

    task automatic plan_run();
        for (int w = 0; w < NP; w++) begin
            int st   = int'(mem[w][K-1:0]);
            int msk  = mask_for(int'(mem[w][Q+K-1:K]));
            exp_q.push_back(mk(1, w, 0, 0, 0, 0, "R2"));
            exp_q.push_back(mk(0, 0, 0, 0, 0, 0, "R5"));
            for (int j = 0; j < M; j++) begin
                int ob = (st >> (K - 1)) & 1;
                int fb = $countones(st & msk) & 1;
                exp_q.push_back(mk(0, 0, 1, ob[0], 0, 0, (j == 0) ? "R3" : "R4"));
                st = ((st << 1) | fb) & ((1 << K) - 1);
            end
            exp_q.push_back(mk(0, 0, 0, 0, 1, 0, "R7"));
        end
        exp_q.push_back(mk(0, 0, 0, 0, 0, 1, "R8"));
    endtask

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic step();
        exp_t e;
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else e = mk(0, 0, 0, 0, 0, 0, "R1");
        if (mem_rd_en) reads++;
        if (scan_en && word_idx < NP && bit_idx < M) begin
            chain[word_idx][bit_idx] = scan_out;
            bit_idx++;
        end
        if (pattern_ready) begin word_idx++; bit_idx = 0; end
        check({mem_rd_en, scan_en, scan_out, pattern_ready, done} ==
              {e.rd_en, e.sen, e.sbit, e.rdy, e.dn}, e.tag, "outputs",
              int'({mem_rd_en, scan_en, scan_out, pattern_ready, done}),
              int'({e.rd_en, e.sen, e.sbit, e.rdy, e.dn}));
        if (e.rd_en) check(int'(mem_addr) == e.addr, "R2", "address", int'(mem_addr), e.addr);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        finish_up();
    end

    initial begin
        mem[0] = {4'd0, 4'b0001};
        mem[1] = {4'd1, 4'b1000};
        mem[2] = {4'd7, 4'b0001};
        mem[3] = {4'd0, 4'b0000};
        repeat (3) step();                 // R1: outputs held low in reset
        rst_n = 1'b1;
        repeat (3) step();                 // R1: idle after release
        // First run
        start = 1'b1;
        plan_run();
        step();
        start = 1'b0;
        for (int c = 0; c < 8; c++) step();
        start = 1'b1;                      // R9: start pulse during shifting
        step();
        start = 1'b0;
        while (exp_q.size() > 0) step();
        repeat (4) step();                 // R8: idle after done
        check(reads == NP, "R9", "read count", reads, NP);
        // R10: target cube care bits for seed 0001, selector 0
        check(chain[0][0] == 1'b0, "R10", "care bit 0", int'(chain[0][0]), 0);
        check(chain[0][4] == 1'b0, "R10", "care bit 4", int'(chain[0][4]), 0);
        check(chain[0][3] == 1'b1, "R10", "care bit 3", int'(chain[0][3]), 1);
        check(chain[0][6] == 1'b1, "R10", "care bit 6", int'(chain[0][6]), 1);
        check(chain[0][9] == 1'b1, "R10", "care bit 9", int'(chain[0][9]), 1);
        for (int j = 0; j < M; j++) begin
            check(chain[2][j] == chain[0][j], "R6", "fallback bit", int'(chain[2][j]), int'(chain[0][j]));
            check(chain[3][j] == 1'b0, "R11", "zero seed bit", int'(chain[3][j]), 0);
        end
        // Second run with different words: selector 1 and mixed seeds
        mem[0] = {4'd1, 4'b0110};
        mem[1] = {4'd0, 4'b1011};
        mem[2] = {4'd15, 4'b1111};
        mem[3] = {4'd1, 4'b0001};
        reads = 0; word_idx = 0; bit_idx = 0;
        start = 1'b1;
        plan_run();
        step();
        start = 1'b0;
        while (exp_q.size() > 0) step();
        repeat (3) step();
        check(reads == NP, "R2", "read count second run", reads, NP);
        finish_up();
    end
endmodule